// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a general-purpose I/O port of `N_PINS` pins (32 by default) on a simple word-wide register bus. Every pin has an output latch and a drive-enable latch. Software changes pins through a write-one-to-set register and a write-one-to-clear register, so several processes can change different pins without a read-modify-write. A write to either register also turns the addressed pins into driven outputs. A separate write-one-to-release register turns pins back into undriven inputs.

Pin levels pass through a two-stage synchroniser and are read from a pin-level register. The port powers up with its inputs dead: the pin-level register reads zero until software has written at least once, with any value, to the same offset. From then on the inputs stay live until reset. Reads are combinational: `bus_rdata` is valid in the same cycle that a read is presented. Writes take effect at the rising clock edge that samples them.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero and every register reads zero, whatever the pin levels are.
- R2: A write to offset 0x108 sets `pin_out` and `pin_oe` for each bit written as 1 at the next clock edge. Bits written as 0 keep their previous output and drive-enable values.
- R3: A write to offset 0x10C clears `pin_out` and sets `pin_oe` for each bit written as 1 at the next clock edge. Bits written as 0 keep their previous values.
- R4: A write to offset 0x100 clears `pin_oe` for each bit written as 1 and leaves `pin_out` unchanged. A read of 0x100 returns `pin_oe`, where bit value 1 means the pin is driven.
- R5: A read of 0x108 returns the output latch (`pin_out`) in the same cycle.
- R6: Until the input-enable flag is set, a read of 0x110 returns zero for any pin levels.
- R7: Any write to 0x110, including a write of zero, sets the input-enable flag. The flag stays set until reset, and the write changes neither `pin_out` nor `pin_oe`.
- R8: Once inputs are enabled, a level applied to `pin_in` between two clock edges appears in a 0x110 read after the second rising edge that follows, not after the first.
- R9: Reads of any other offset, and of 0x10C, return zero. Writes to other offsets, and cycles with no write, leave `pin_out` and `pin_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | N_PINS (32) | Write data; each bit is a pin mask |
| bus_rdata | output | N_PINS (32) | Read data, combinational |
| pin_in | input | N_PINS (32) | Asynchronous pin levels from the pads |
| pin_out | output | N_PINS (32) | Output latch values to the pads |
| pin_oe | output | N_PINS (32) | Drive enable per pin, 1 = driven |

## Verification
A wrong latch bit shows on `pin_out` or `pin_oe` right after the edge that should have written it. This includes a masked-off pin that moved, which is what the zero-mask writes target. A stuck or early input-enable flag shows as non-zero pin-level reads while the pins are driven to a non-zero pattern before the enable write. A synchroniser with the wrong depth shows in the read taken between the first and second edge after a pin change.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    // Register byte offsets (software-visible map)
    localparam logic [31:0] OFS_DRIVE  = 32'h100;  // read: drive enables, write: release
    localparam logic [31:0] OFS_SET    = 32'h108;  // read: output latch, write: set+drive
    localparam logic [31:0] OFS_CLR    = 32'h10C;  // write: clear+drive
    localparam logic [31:0] OFS_LEVEL  = 32'h110;  // read: pin levels, write: input enable

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DRIVE,
        REG_SET,
        REG_CLR,
        REG_LEVEL
    } gsc_reg_e;

endpackage

// File: rtl/gsc_decode.sv
module gsc_decode
    import gsc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output gsc_reg_e          reg_sel
);

    always_comb begin
        if (addr == OFS_DRIVE[ADDR_W-1:0])
            reg_sel = REG_DRIVE;
        else if (addr == OFS_SET[ADDR_W-1:0])
            reg_sel = REG_SET;
        else if (addr == OFS_CLR[ADDR_W-1:0])
            reg_sel = REG_CLR;
        else if (addr == OFS_LEVEL[ADDR_W-1:0])
            reg_sel = REG_LEVEL;
        else
            reg_sel = REG_NONE;
    end

endmodule

// File: rtl/gsc_pin_bank.sv
module gsc_pin_bank #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_set,
    input  logic              do_clr,
    input  logic              do_release,
    input  logic [N_PINS-1:0] mask,
    output logic [N_PINS-1:0] out_lat,
    output logic [N_PINS-1:0] oe_lat
);

    typedef struct packed {
        logic [N_PINS-1:0] out;
        logic [N_PINS-1:0] oe;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (do_set) begin
            bank_d.out = bank_q.out | mask;
            bank_d.oe  = bank_q.oe  | mask;
        end else if (do_clr) begin
            bank_d.out = bank_q.out & ~mask;
            bank_d.oe  = bank_q.oe  | mask;
        end else if (do_release) begin
            bank_d.oe  = bank_q.oe  & ~mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign out_lat = bank_q.out;
    assign oe_lat  = bank_q.oe;

endmodule

// File: rtl/gsc_in_sync.sv
module gsc_in_sync #(
    parameter int N_PINS = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [N_PINS-1:0] pin_async,
    output logic [N_PINS-1:0] level_vis
);

    typedef struct packed {
        logic [STAGES-1:0][N_PINS-1:0] chain;
        logic                          live;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = pin_async;
        for (int s = 1; s < STAGES; s++)
            sync_d.chain[s] = sync_q.chain[s-1];
        if (arm)
            sync_d.live = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= sync_d;
    end

    assign level_vis = sync_q.chain[STAGES-1] & {N_PINS{sync_q.live}};

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gsc_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);

    gsc_reg_e          reg_sel;
    logic              wr_act;
    logic              rd_act;
    logic [N_PINS-1:0] level_vis;

    assign wr_act = bus_sel &&  bus_we;
    assign rd_act = bus_sel && !bus_we;

    gsc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .reg_sel (reg_sel)
    );

    gsc_pin_bank #(.N_PINS(N_PINS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_set     (wr_act && reg_sel == REG_SET),
        .do_clr     (wr_act && reg_sel == REG_CLR),
        .do_release (wr_act && reg_sel == REG_DRIVE),
        .mask       (bus_wdata),
        .out_lat    (pin_out),
        .oe_lat     (pin_oe)
    );

    gsc_in_sync #(.N_PINS(N_PINS), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (wr_act && reg_sel == REG_LEVEL),
        .pin_async (pin_in),
        .level_vis (level_vis)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_act) begin
            unique case (reg_sel)
                REG_DRIVE: bus_rdata = pin_oe;
                REG_SET:   bus_rdata = pin_out;
                REG_LEVEL: bus_rdata = level_vis;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gsc_checker.sv
module gsc_checker
    import gsc_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe
);

    logic wr_set, wr_clr, wr_rel, wr_lvl, rd_lvl, rd_out, rd_drv, en_seen_q;

    assign wr_set = bus_sel && bus_we && bus_addr == OFS_SET[ADDR_W-1:0];
    assign wr_clr = bus_sel && bus_we && bus_addr == OFS_CLR[ADDR_W-1:0];
    assign wr_rel = bus_sel && bus_we && bus_addr == OFS_DRIVE[ADDR_W-1:0];
    assign wr_lvl = bus_sel && bus_we && bus_addr == OFS_LEVEL[ADDR_W-1:0];
    assign rd_lvl = bus_sel && !bus_we && bus_addr == OFS_LEVEL[ADDR_W-1:0];
    assign rd_out = bus_sel && !bus_we && bus_addr == OFS_SET[ADDR_W-1:0];
    assign rd_drv = bus_sel && !bus_we && bus_addr == OFS_DRIVE[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_seen_q <= 1'b0;
        else if (wr_lvl)
            en_seen_q <= 1'b1;
    end

    AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
                   ((pin_oe  & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))); // R2

    AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata)) == '0) &&
                   ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rel |=> ((pin_oe & $past(bus_wdata)) == '0) && $stable(pin_out)); // R4

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drv |-> bus_rdata == pin_oe); // R4

    AST_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> bus_rdata == pin_out); // R5

    AST_DEAD_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lvl && !en_seen_q) |-> bus_rdata == '0); // R6

    AST_ENABLE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lvl |=> $stable(pin_out) && $stable(pin_oe)); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr || wr_rel) |=> $stable(pin_out) && $stable(pin_oe)); // R9

endmodule

bind gpio_setclr_port gsc_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_port_test.sv
module gpio_setclr_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    logic [NP-1:0] exp_out = '0;
    logic [NP-1:0] exp_oe  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr_port #(.N_PINS(NP), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write: presented at a falling edge, sampled by the next rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Read: combinational, no clock edge consumed.
    task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic check_latches(input string tag);
        chk({tag, " pin_out"}, pin_out, exp_out);
        chk({tag, " pin_oe"},  pin_oe,  exp_oe);
    endtask

    task automatic t_reset();
        logic [NP-1:0] v;
        pin_in = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_latches("R1 reset");
        rd(12'h100, v); chk("R1 drive reg", v, '0);
        rd(12'h108, v); chk("R1 output reg", v, '0);
        rd(12'h110, v); chk("R1 level reg", v, '0);
    endtask

    task automatic t_set();
        logic [NP-1:0] v;
        wr(12'h108, 32'h0000_00F1);
        exp_out = 32'h0000_00F1; exp_oe = 32'h0000_00F1;
        check_latches("R2 set low byte");
        wr(12'h108, 32'h8000_0000);
        exp_out = 32'h8000_00F1; exp_oe = 32'h8000_00F1;
        check_latches("R2 set top bit, others kept");
        rd(12'h108, v); chk("R5 output readback", v, exp_out);
    endtask

    task automatic t_clr();
        logic [NP-1:0] v;
        wr(12'h10C, 32'h0000_0011);
        exp_out = 32'h8000_00E0;
        check_latches("R3 clear masked");
        wr(12'h10C, 32'h0000_0F00);
        exp_oe = 32'h8000_0FF1;
        check_latches("R3 clear makes outputs");
        rd(12'h108, v); chk("R5 output after clear", v, exp_out);
        rd(12'h10C, v); chk("R9 clear offset reads zero", v, '0);
    endtask

    task automatic t_release();
        logic [NP-1:0] v;
        wr(12'h100, 32'h0000_0F01);
        exp_oe = 32'h8000_00F0;
        check_latches("R4 release");
        rd(12'h100, v); chk("R4 drive readback", v, exp_oe);
    endtask

    task automatic t_dead();
        logic [NP-1:0] v;
        pin_in = 32'hA5A5_5A5A;
        repeat (4) @(negedge clk);
        rd(12'h110, v); chk("R6 inputs dead before enable", v, '0);
    endtask

    task automatic t_enable();
        logic [NP-1:0] v;
        wr(12'h110, 32'h0);
        check_latches("R7 enable write leaves latches");
        rd(12'h110, v); chk("R7 levels live after zero write", v, 32'hA5A5_5A5A);
        wr(12'h110, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        rd(12'h110, v); chk("R7 flag sticky", v, 32'hA5A5_5A5A);
        check_latches("R7 second enable write leaves latches");
    endtask

    task automatic t_sync();
        logic [NP-1:0] v;
        pin_in = 32'h3C3C_C3C3;
        rd(12'h110, v); chk("R8 no edge yet", v, 32'hA5A5_5A5A);
        @(negedge clk);
        rd(12'h110, v); chk("R8 after first edge", v, 32'hA5A5_5A5A);
        @(negedge clk);
        rd(12'h110, v); chk("R8 after second edge", v, 32'h3C3C_C3C3);
    endtask

    task automatic t_unmapped();
        logic [NP-1:0] v;
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h118, 32'hFFFF_FFFF);
        check_latches("R9 unmapped writes");
        rd(12'h104, v); chk("R9 unmapped read 104", v, '0);
        rd(12'h114, v); chk("R9 unmapped read 114", v, '0);
        repeat (3) @(negedge clk);
        check_latches("R9 idle cycles");
    endtask

    initial begin
        t_reset();
        t_set();
        t_clr();
        t_release();
        t_dead();
        t_enable();
        t_sync();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule